// File: doc/BRIEF.md
# Sampled Glitch Filter Edge Detector

This block is the front end for a bank of external interrupt pins. Each raw pin passes through a two-flop synchronizer. It is then sampled only on a single-cycle tick from a programmable divider of the system clock. The filtered level of a pin moves to a new value only after three tick samples in a row agree on it. Any pulse that shorter sampling windows see is dropped as noise.

Each change of the filtered level can raise a one-cycle interrupt request. Two per-pin enable registers choose which changes count. The first register enables changes to high, and the second enables changes to low. A pin can use either direction, both directions, or none. Software loads the two registers through a small write port. Reset clears both registers, so no pin raises a request until software enables edges on it.

Top module: `pin_event_filter`

## Requirements
- R1: The tick used for sampling comes from a counter that restarts on every tick. With divider input value D, the tick occurs once every D+1 system cycles, and D=0 gives a tick in every cycle. After a raw pin change, the filtered level changes between 2(D+1)+3 and 3(D+1)+2 cycles later. This delay includes the two synchronizer flops.
- R2: The filtered level of a pin takes a new value only when three consecutive tick samples all hold that value. A pulse that lasts no more than two tick periods leaves the filtered level and the request output unchanged.
- R3: When a pin's filtered level changes from 0 to 1 and its bit in the rising-enable register is 1, a request is raised on that pin. When the rising bit is 0, that change raises no request.
- R4: When a pin's filtered level changes from 1 to 0 and its bit in the falling-enable register is 1, a request is raised on that pin. When the falling bit is 0, that change raises no request.
- R5: A pin with both enable bits set raises a request on both directions of change. A pin with both bits clear raises none, and its filtered level still follows the input.
- R6: A request on `irq_o[i]` lasts exactly one system cycle. It is high in the same cycle in which `level_o[i]` first shows the new value.
- R7: While reset is asserted, and in the cycle after it, `irq_o`, `level_o` and both enable registers are zero. A pin held high through reset later settles `level_o` to 1 without raising a request.
- R8: A write with `wr_en_i`=1 loads `wr_data_i` into the rising-enable register when `wr_sel_i`=0, and into the falling-enable register when `wr_sel_i`=1. The other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Raw asynchronous interrupt pins |
| tick_div_i | input | DIV_W | Divider value D; tick period is D+1 cycles |
| wr_en_i | input | 1 | Enable register write strobe |
| wr_sel_i | input | 1 | 0 selects the rising-enable register, 1 selects the falling-enable register |
| wr_data_i | input | NUM_PINS | Data written to the selected enable register |
| level_o | output | NUM_PINS | Filtered pin levels |
| irq_o | output | NUM_PINS | One-cycle interrupt request per pin |

## Verification
The assertions assume that `tick_div_i` changes only while no pin is in the middle of a level change. They also assume that enable writes are separated from filter acceptances that depend on them. The stimulus meets both conditions. It changes the divider and the enable registers only after the filters have settled. It spaces every pin change by more than four tick periods, so each expected request falls inside its own timing window. Glitches are driven for exactly two tick periods, which is the longest pulse that the filter must reject.

// File: rtl/pef_pkg.sv
package pef_pkg;

  typedef enum logic {
    SEL_RISE = 1'b0,
    SEL_FALL = 1'b1
  } en_sel_e;

endpackage

// File: rtl/pef_sync.sv
module pef_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pef_tick.sv
module pef_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic             wrap;

  assign wrap = (cnt_q >= div_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  // R1: a nonzero divider never gives back-to-back ticks
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    (tick_q && div_i != '0) |=> !tick_q);

endmodule

// File: rtl/pef_filter.sv
module pef_filter #(
  parameter int MATCH_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic sample_i,
  output logic level_o,
  output logic accept_o,
  output logic next_o
);

  localparam int HIST_W = MATCH_LEN - 1;

  logic [HIST_W-1:0] hist_q;
  logic              level_q;
  logic              agree;

  assign agree    = tick_i && (hist_q == {HIST_W{sample_i}});
  assign accept_o = agree && (sample_i != level_q);
  assign next_o   = sample_i;

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)         hist_q <= '0;
        else if (tick_i) hist_q <= sample_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)         hist_q <= '0;
        else if (tick_i) hist_q <= {hist_q[HIST_W-2:0], sample_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           level_q <= 1'b0;
    else if (accept_o) level_q <= sample_i;
  end

  assign level_o = level_q;

  // R2: the level moves only on a tick, and only to the value just sampled
  assert_level_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> ($past(tick_i) && level_q == $past(sample_i)));

endmodule

// File: rtl/pef_edge.sv
module pef_edge
  import pef_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] accept_i,
  input  logic [NUM_PINS-1:0] next_i,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic                wr_en_i,
  input  en_sel_e             wr_sel_i,
  input  logic [NUM_PINS-1:0] wr_data_i,
  output logic [NUM_PINS-1:0] irq_o
);

  logic [NUM_PINS-1:0] rise_q;
  logic [NUM_PINS-1:0] fall_q;
  logic [NUM_PINS-1:0] irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_RISE: rise_q <= wr_data_i;
        SEL_FALL: fall_q <= wr_data_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= accept_i & ((next_i & rise_q) | (~next_i & fall_q));
  end

  assign irq_o = irq_q;

  // R7: reset leaves no request and no enabled edge
  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |=> (irq_q == '0 && rise_q == '0 && fall_q == '0));

  // R8: a rising-register write leaves the falling register alone
  assert_wr_isolated_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_sel_i == SEL_RISE) |=> $stable(fall_q));

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
      // R6: request coincides with the visible level change and lasts one cycle
      assert_irq_with_level_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q[i] |-> (level_i[i] != $past(level_i[i])));
      assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q[i] |=> !irq_q[i]);
      // R3 / R4: request direction matches an enabled bit
      assert_irq_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_q[i] && level_i[i]) |-> $past(rise_q[i]));
      assert_irq_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_q[i] && !level_i[i]) |-> $past(fall_q[i]));
    end
  endgenerate

endmodule

// File: rtl/pin_event_filter.sv
module pin_event_filter
  import pef_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MATCH_LEN   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [DIV_W-1:0]    tick_div_i,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [NUM_PINS-1:0] wr_data_i,
  output logic [NUM_PINS-1:0] level_o,
  output logic [NUM_PINS-1:0] irq_o
);

  logic [NUM_PINS-1:0] synced;
  logic [NUM_PINS-1:0] accept;
  logic [NUM_PINS-1:0] next_lvl;
  logic [NUM_PINS-1:0] level;
  logic                tick;

  pef_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (pin_i),
    .sync_o (synced)
  );

  pef_tick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .div_i  (tick_div_i),
    .tick_o (tick)
  );

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pef_filter #(.MATCH_LEN(MATCH_LEN)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .sample_i (synced[i]),
        .level_o  (level[i]),
        .accept_o (accept[i]),
        .next_o   (next_lvl[i])
      );
    end
  endgenerate

  pef_edge #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept),
    .next_i    (next_lvl),
    .level_i   (level),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (en_sel_e'(wr_sel_i)),
    .wr_data_i (wr_data_i),
    .irq_o     (irq_o)
  );

  assign level_o = level;

endmodule

// File: tb/pin_event_filter_test.sv
module pin_event_filter_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pin_i = '0;
  logic [DW-1:0] tick_div_i = 16'd3;
  logic          wr_en_i = 1'b0;
  logic          wr_sel_i = 1'b0;
  logic [N-1:0]  wr_data_i = '0;
  logic [N-1:0]  level_o;
  logic [N-1:0]  irq_o;

  pin_event_filter #(.NUM_PINS(N), .DIV_W(DW)) uut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .tick_div_i(tick_div_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .level_o(level_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    pin;
    int    lo;
    int    hi;
    string req;
  } exp_t;

  exp_t   sb[$];
  int     cyc = 0;
  int     period = 4;
  int     n_checks = 0;
  int     n_fail = 0;
  logic [N-1:0] prev_irq = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_irq(input int p, input string req);
    exp_t e;
    e.pin = p;
    e.lo  = cyc + 2*period + 2;
    e.hi  = cyc + 3*period + 3;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    idle(4*period + 8);
  endtask

  task automatic drive(input int p, input bit v);
    @(negedge clk);
    pin_i[p] = v;
  endtask

  task automatic write_en(input bit sel, input logic [N-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // monitor: pops the scoreboard as requests appear
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        if (irq_o[i]) begin
          check(!prev_irq[i], "R6", $sformatf("request wider than one cycle pin %0d", i), 1, 0);
          if (sb.size() == 0) begin
            check(1'b0, "R5", $sformatf("unexpected request pin %0d", i), 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.pin == i, e.req, "request pin", i, e.pin);
            check(cyc >= e.lo && cyc <= e.hi, "R1",
                  $sformatf("request cycle (window %0d..%0d)", e.lo, e.hi), cyc, e.lo);
          end
        end
      end
      prev_irq = irq_o;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    pin_i[7] = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(irq_o == '0, "R7", "irq after reset", int'(irq_o), 0);
    check(level_o == '0, "R7", "level after reset", int'(level_o), 0);
    settle();
    check(level_o[7] == 1'b1, "R7", "pin held high settles", int'(level_o[7]), 1);

    // nothing enabled: level follows, no request
    drive(0, 1'b1); settle();
    check(level_o[0] == 1'b1, "R7", "level0 with edges off", int'(level_o[0]), 1);
    drive(0, 1'b0); settle();
    check(level_o[0] == 1'b0, "R7", "level0 back low", int'(level_o[0]), 0);

    // rise on 0,2,4,5 ; fall on 1,2,7 ; pin 3 none
    write_en(1'b0, 8'b0011_0101);
    write_en(1'b1, 8'b1000_0110);

    drive(0, 1'b1); expect_irq(0, "R3"); settle();
    drive(0, 1'b0); settle();
    check(level_o[0] == 1'b0, "R3", "fall on rise-only pin", int'(level_o[0]), 0);

    drive(1, 1'b1); settle();
    check(level_o[1] == 1'b1, "R4", "rise on fall-only pin", int'(level_o[1]), 1);
    drive(1, 1'b0); expect_irq(1, "R4"); settle();

    drive(2, 1'b1); expect_irq(2, "R5"); settle();
    drive(2, 1'b0); expect_irq(2, "R5"); settle();

    drive(3, 1'b1); settle();
    check(level_o[3] == 1'b1, "R5", "disabled pin level high", int'(level_o[3]), 1);
    drive(3, 1'b0); settle();
    check(level_o[3] == 1'b0, "R5", "disabled pin level low", int'(level_o[3]), 0);

    // two pins together
    @(negedge clk);
    pin_i[4] = 1'b1; pin_i[5] = 1'b1;
    expect_irq(4, "R3"); expect_irq(5, "R3");
    settle();

    // glitch of two tick periods is rejected
    drive(0, 1'b1); idle(2*period - 1); drive(0, 1'b0); settle();
    check(level_o[0] == 1'b0, "R2", "glitch rejected", int'(level_o[0]), 0);
    // longer pulse is accepted
    drive(0, 1'b1); expect_irq(0, "R2"); settle();
    check(level_o[0] == 1'b1, "R2", "held pulse accepted", int'(level_o[0]), 1);
    drive(0, 1'b0); settle();

    drive(7, 1'b0); expect_irq(7, "R4"); settle();

    // rising register cleared, falling register kept
    write_en(1'b0, 8'h00);
    drive(2, 1'b1); settle();
    check(level_o[2] == 1'b1, "R8", "pin2 level after rise", int'(level_o[2]), 1);
    drive(2, 1'b0); expect_irq(2, "R8"); settle();

    // divider of zero: tick every cycle
    @(negedge clk);
    tick_div_i = '0;
    period = 1;
    settle();
    drive(1, 1'b1); settle();
    drive(1, 1'b0); expect_irq(1, "R1"); settle();
    drive(2, 1'b1); idle(1); drive(2, 1'b0); settle();
    check(level_o[2] == 1'b0, "R2", "short glitch at fast tick", int'(level_o[2]), 0);

    settle();
    check(sb.size() == 0, "R6", "outstanding expected requests", sb.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule